// File: doc/BRIEF.md
# Handshake Serial Packet Transmitter

This block is the host-side sender of a three-wire serial link made of a data line, a host-driven acknowledge line and a device-driven clock line. The host loads a packet of one to eight bytes and pulses `start`. The block pulls the data line low as a request to send. Each bit is then paced by a two-way handshake: the host flips the acknowledge line, and the device flips its clock line in reply.

After the payload, the block sends an even-parity bit and then a stop phase. During the stop phase the device may cancel the packet by holding the data line low. The result is reported with a one-cycle `done` pulse and exactly one status flag:

- `ok` when the packet was accepted.
- `flushed` when the device cancelled it. A separate flush-receiving sequence then takes over.
- `timed_out` when the device failed to answer any handshake step within `TIMEOUT` cycles.

Top module: `hs_pkt_tx`

## Requirements
- R1: A start with a byte count from 1 to MAX_BYTES makes the block drive the data line low with the acknowledge line still high. Only after the device clock reads low does the acknowledge line go low, while the data line stays low.
- R2: Once the device clock reads high again, the first payload bit is placed on the data line and the acknowledge line rises.
- R3: Payload bits leave least-significant bit of byte 0 first, byte by byte, 8 times the byte count in all. Each new bit, with its acknowledge flip, appears only after the device clock has changed to differ from the acknowledge line.
- R4: While busy, the data line value changes only in a cycle where the acknowledge line also changes.
- R5: After the last payload bit, the data line carries a parity bit: 1 for an odd number of one-bits in the sent payload, 0 for an even number. The acknowledge line rises with it.
- R6: When the device clock then reads low, the block drives the data line high as the stop bit and lowers the acknowledge line. After the device clock reads high, it releases the data line.
- R7: If the released data line reads low one cycle after release, the block ends with `done` plus `flushed`, and `ok` low.
- R8: If the released data line reads high, the block raises the acknowledge line and ends with `done` plus `ok`.
- R9: If any wait for the device clock lasts TIMEOUT cycles, the block releases the line, raises the acknowledge line and ends with `done` plus `timed_out`.
- R10: A start is ignored when the byte count is 0 or above MAX_BYTES, or while a transfer is in progress. An ignored start changes neither the lines nor the data being sent.
- R11: `done` is a single-cycle pulse with exactly one of `ok`, `flushed`, `timed_out` set. While not busy, the data line is released and the acknowledge line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send the loaded packet |
| nbytes | input | 4 | Byte count of the packet, 1 to MAX_BYTES |
| payload | input | 64 | Packet bytes, byte 0 in bits 7:0 |
| dev_clk | input | 1 | Device clock line, already synchronous to clk |
| line_data | input | 1 | Sampled level of the shared data line |
| data_out | output | 1 | Value driven onto the data line |
| data_oe | output | 1 | Drive enable for the data line |
| ack_out | output | 1 | Host acknowledge line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ok | output | 1 | Transfer accepted, valid with done |
| flushed | output | 1 | Device cancelled the packet, valid with done |
| timed_out | output | 1 | Device did not answer in time, valid with done |

## Verification
The assertions assume that `dev_clk` and `line_data` arrive already synchronized to `clk`. They also assume the device flips its clock only in reply to an acknowledge change. The bench's device model therefore changes its lines only on falling clock edges, after it has observed the acknowledge line match its own clock. It waits a random zero to three cycles before each reply, which stays well below the shortened timeout. Timeout cases are produced by making the model stop answering at a chosen handshake step. Flush cases are produced by having it pull the line low before the final clock rise.

// File: rtl/hs_pkt_tx.sv
module hs_pkt_tx #(
  parameter int MAX_BYTES = 8,
  parameter int TIMEOUT   = 1024,
  localparam int NBW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NBW-1:0]         nbytes,
  input  logic [8*MAX_BYTES-1:0] payload,
  input  logic                   dev_clk,
  input  logic                   line_data,
  output logic                   data_out,
  output logic                   data_oe,
  output logic                   ack_out,
  output logic                   busy,
  output logic                   done,
  output logic                   ok,
  output logic                   flushed,
  output logic                   timed_out
);
  localparam int NBITS = 8 * MAX_BYTES;
  localparam int BW    = $clog2(NBITS);
  localparam int BYW   = $clog2(MAX_BYTES);
  localparam int TW    = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_RTS, S_SYNC, S_SHIFT, S_PAR, S_STOP, S_CHK} st_t;

  st_t              st;
  logic [NBITS-1:0] pl;
  logic [BW-1:0]    idx;
  logic [BYW-1:0]   nbm1;
  logic             par;
  logic [TW-1:0]    tmo;

  wire accept  = (st == S_IDLE) && start && (nbytes != '0) && (nbytes <= NBW'(MAX_BYTES));
  wire waiting = (st != S_IDLE) && (st != S_CHK);
  wire advance = waiting && (dev_clk != ack_out);
  wire expire  = waiting && !advance && (tmo == TW'(TIMEOUT - 1));
  wire last    = (idx[BW-1:3] == nbm1) && (idx[2:0] == 3'b111);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pl <= '0;
      idx <= '0;
      nbm1 <= '0;
      par <= 1'b0;
      tmo <= '0;
      data_out <= 1'b1;
      data_oe <= 1'b0;
      ack_out <= 1'b1;
      done <= 1'b0;
      ok <= 1'b0;
      flushed <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      done <= 1'b0;
      ok <= 1'b0;
      flushed <= 1'b0;
      timed_out <= 1'b0;
      tmo <= (advance || !waiting) ? '0 : tmo + TW'(1);
      if (expire) begin
        st <= S_IDLE;
        data_oe <= 1'b0;
        data_out <= 1'b1;
        ack_out <= 1'b1;
        done <= 1'b1;
        timed_out <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (accept) begin
            pl <= payload;
            nbm1 <= BYW'(nbytes - NBW'(1));
            data_out <= 1'b0;
            data_oe <= 1'b1;
            st <= S_RTS;
          end
          S_RTS: if (advance) begin
            ack_out <= 1'b0;
            st <= S_SYNC;
          end
          S_SYNC: if (advance) begin
            data_out <= pl[0];
            par <= pl[0];
            idx <= '0;
            ack_out <= 1'b1;
            st <= S_SHIFT;
          end
          S_SHIFT: if (advance) begin
            ack_out <= ~ack_out;
            if (last) begin
              data_out <= par;
              st <= S_PAR;
            end else begin
              data_out <= pl[1];
              par <= par ^ pl[1];
              pl <= pl >> 1;
              idx <= idx + BW'(1);
            end
          end
          S_PAR: if (advance) begin
            data_out <= 1'b1;
            ack_out <= 1'b0;
            st <= S_STOP;
          end
          S_STOP: if (advance) begin
            data_oe <= 1'b0;
            st <= S_CHK;
          end
          S_CHK: begin
            done <= 1'b1;
            ack_out <= 1'b1;
            ok <= line_data;
            flushed <= !line_data;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module hs_pkt_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ok,
  input logic flushed,
  input logic timed_out,
  input logic data_out,
  input logic data_oe,
  input logic ack_out,
  input logic dev_clk
);
  AST_RTS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> data_oe && !data_out && ack_out); // R1
  AST_ACK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(ack_out) |-> $past(dev_clk != ack_out)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $stable(ack_out) |-> $stable(data_out)); // R4
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({ok, flushed, timed_out}) == 1); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !data_oe && ack_out); // R11
endmodule

bind hs_pkt_tx hs_pkt_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ok(ok),
  .flushed(flushed), .timed_out(timed_out), .data_out(data_out),
  .data_oe(data_oe), .ack_out(ack_out), .dev_clk(dev_clk)
);

// File: tb/sim_hs_pkt_tx.sv
`timescale 1ns/1ps
module sim_hs_pkt_tx;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] nbytes = 4'd1;
  logic [63:0] payload = '0;
  logic dev_clk = 1'b1, dev_low = 1'b0;
  logic data_out, data_oe, ack_out, busy, done, ok, flushed, timed_out;
  logic line_data;
  logic [72:0] cap;
  int checks = 0, fails = 0;

  assign line_data = (data_oe ? data_out : 1'b1) & ~dev_low;
  always #2.5 clk = ~clk;

  hs_pkt_tx #(.MAX_BYTES(8), .TIMEOUT(40)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .nbytes(nbytes), .payload(payload),
    .dev_clk(dev_clk), .line_data(line_data), .data_out(data_out), .data_oe(data_oe),
    .ack_out(ack_out), .busy(busy), .done(done), .ok(ok), .flushed(flushed),
    .timed_out(timed_out));

  task automatic chk(input bit cond, input string what, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input int nb);
    return (nb >= 8) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
  endfunction

  task automatic device(input int nb, input bit fl, input int stall, input int dly);
    while (!(data_oe && !data_out)) @(negedge clk);
    chk(ack_out == 1'b1, "R1 ack high during request", ack_out, 1);
    if (stall == 0) return;
    repeat (dly) @(negedge clk);
    dev_clk = 1'b0;
    @(negedge clk);
    while (ack_out != 1'b0) @(negedge clk);
    chk(data_oe && !data_out, "R1 data low when ack falls", data_out, 0);
    if (stall == 1) return;
    repeat (dly) @(negedge clk);
    dev_clk = 1'b1;
    for (int k = 0; k <= 8 * nb; k++) begin
      @(negedge clk);
      while (ack_out != dev_clk) @(negedge clk);
      if (k == 0) chk(ack_out == 1'b1, "R2 first bit with ack high", ack_out, 1);
      cap[k] = data_out;
      if (stall == k + 2) return;
      repeat (dly) @(negedge clk);
      dev_clk = ~dev_clk;
    end
    @(negedge clk);
    while (ack_out != dev_clk) @(negedge clk);
    chk(data_oe && data_out && !ack_out, "R6 stop bit high with ack low",
        {data_oe, data_out, ack_out}, 3'b110);
    if (fl) dev_low = 1'b1;
    if (stall == 8 * nb + 3) return;
    repeat (dly) @(negedge clk);
    dev_clk = 1'b1;
  endtask

  task automatic run(input int nb, input logic [63:0] pl, input bit fl, input int stall,
                     input int dly, input bit poke);
    logic [63:0] m;
    logic g_ok, g_fl, g_to, cap_ok;
    m = mask_of(nb);
    cap = '0;
    @(negedge clk);
    nbytes = 4'(nb); payload = pl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      device(nb, fl, stall, dly);
      begin
        while (!done) @(negedge clk);
        g_ok = ok; g_fl = flushed; g_to = timed_out;
      end
      begin
        if (poke) begin
          repeat (12) @(negedge clk);
          payload = ~pl; nbytes = 4'd1; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    if (stall < 0) begin
      cap_ok = 1'b1;
      for (int i = 0; i < 8 * nb; i++) if (cap[i] != pl[i]) cap_ok = 1'b0;
      chk(cap_ok, poke ? "R10 busy start left bits unchanged" : "R3 bits sent lsb first",
          cap[63:0] & m, pl & m);
      chk(cap[8 * nb] == ^(pl & m), "R5 parity bit", cap[8 * nb], ^(pl & m));
      if (fl) chk(g_fl && !g_ok && !g_to, "R7 flush status", {g_ok, g_fl, g_to}, 3'b010);
      else    chk(g_ok && !g_fl && !g_to, "R8 ok status", {g_ok, g_fl, g_to}, 3'b100);
    end else begin
      chk(g_to && !g_ok && !g_fl, "R9 timeout status", {g_ok, g_fl, g_to}, 3'b001);
    end
    @(negedge clk);
    chk(!done && !busy && !data_oe && ack_out, "R11 single done then idle lines",
        {done, busy, data_oe, ack_out}, 4'b0001);
    dev_low = 1'b0;
    dev_clk = 1'b1;
  endtask

  task automatic reject(input int nb);
    @(negedge clk);
    nbytes = 4'(nb); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !data_oe && ack_out, "R10 bad count ignored", {busy, data_oe, ack_out}, 3'b001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (4) @(negedge clk);
    chk(!busy && !data_oe && ack_out && !done, "R11 reset state",
        {busy, data_oe, ack_out, done}, 4'b0010);
    rst_n = 1'b1;
    run(1, 64'hA5, 1'b0, -1, 0, 1'b0);
    run(8, '1, 1'b0, -1, 1, 1'b0);
    run(3, 64'h00_0701, 1'b0, -1, 2, 1'b0);
    run(2, 64'h8001, 1'b1, -1, 0, 1'b0);
    run(8, 64'h0123_4567_89AB_CDEF, 1'b0, -1, 0, 1'b1);
    run(2, 64'h1234, 1'b0, 0, 0, 1'b0);
    run(2, 64'h1234, 1'b0, 1, 1, 1'b0);
    run(2, 64'h1234, 1'b0, 7, 0, 1'b0);
    run(2, 64'h1234, 1'b0, 18, 0, 1'b0);
    run(1, 64'h5A, 1'b0, 11, 2, 1'b0);
    reject(0);
    reject(9);
    reject(15);
    for (int t = 0; t < 30; t++) begin
      run(int'($urandom_range(1, 8)), {$urandom, $urandom}, ($urandom_range(0, 3) == 0),
          -1, int'($urandom_range(0, 3)), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule